// File: doc/BRIEF.md
# Byte/Word Load-Store Unit

This unit connects a register datapath to a synchronous, byte-addressed 32-bit data memory. For each request it adds a sign-extended byte displacement to a base register value to form the effective address. It then drives the word address, the byte enables and the write data towards memory. Loads return the formatted result for register writeback.

Five operations are supported: word load, word store, sign-extending byte load, zero-extending byte load and byte store. Word operations must fall on a 4-byte boundary. A word operation that does not is reported on a fault flag and never reaches memory or the register file. Byte operations may use any address. The byte lane is picked by the low two address bits in little-endian order. Memory reads take one cycle, so a load result shows up on the writeback port in the cycle after the request.

Top module: `lsu_top`

## Requirements
- R1: The effective address equals `base_i` plus `offset_i` sign-extended to 32 bits, modulo 2^32; `mem_addr_o` carries that address with its two low bits forced to zero.
- R2: A word load or word store whose effective address has nonzero low two bits asserts `misalign_o` in the request cycle, keeps `mem_req_o` and `mem_we_o` low, and produces no `wb_valid_o` in the following cycle.
- R3: An aligned word load (`op_i`=0) drives `mem_req_o`=1, `mem_we_o`=0, and one cycle later asserts `wb_valid_o` with `wb_data_o` equal to the full memory word.
- R4: An aligned word store (`op_i`=1) drives `mem_req_o`=1, `mem_we_o`=1, `mem_be_o`=4'b1111 and `mem_wdata_o`=`store_data_i`.
- R5: A signed byte load (`op_i`=2) returns the byte in lane n = address[1:0] (bits 8n+7..8n of the word), with bits 31..8 equal to copies of that byte's bit 7.
- R6: An unsigned byte load (`op_i`=3) returns the selected lane byte with bits 31..8 zero.
- R7: A byte store (`op_i`=4) drives `mem_be_o` with only bit n set (n = address[1:0]) and `mem_wdata_o` with `store_data_i[7:0]` copied into all four lanes, so the other three bytes of the memory word keep their value.
- R8: Byte loads and byte stores never assert `misalign_o`, whatever the low address bits are.
- R9: After reset, and whenever `req_valid_i` is low or `op_i` is 5, 6 or 7, the unit issues no memory access and no writeback in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| op_i | input | 3 | 0 word load, 1 word store, 2 signed byte load, 3 unsigned byte load, 4 byte store |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed byte displacement |
| store_data_i | input | 32 | Source register value for stores |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Write data, lane-replicated for byte stores |
| mem_rdata_i | input | 32 | Read word, valid one cycle after a read strobe |
| misalign_o | output | 1 | Word access on an unaligned address |
| wb_valid_o | output | 1 | Load result valid |
| wb_data_o | output | 32 | Formatted load result |

## Verification
A word is first stored with a distinct sign pattern in each lane: 0x15 and 0x7F are positive, 0xC3 and 0x80 are negative. Byte loads of both kinds then read every lane, which separates lane selection from extension polarity. A byte store into one lane followed by a word load shows whether the neighbouring bytes survive. Word accesses at each unaligned offset, a negative displacement, idle cycles and unused op codes separate address arithmetic and fault gating from the normal path.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [2:0] {
    OP_LW  = 3'd0,
    OP_SW  = 3'd1,
    OP_LB  = 3'd2,
    OP_LBU = 3'd3,
    OP_SB  = 3'd4
  } lsu_op_e;

  typedef struct packed {
    logic load;
    logic store;
    logic word;
    logic sext;
  } lsu_dec_t;

  function automatic lsu_dec_t lsu_decode(logic [2:0] op);
    lsu_dec_t d;
    d = '0;
    case (op)
      OP_LW:   begin d.load = 1'b1; d.word = 1'b1; end
      OP_SW:   begin d.store = 1'b1; d.word = 1'b1; end
      OP_LB:   begin d.load = 1'b1; d.sext = 1'b1; end
      OP_LBU:  d.load = 1'b1;
      OP_SB:   d.store = 1'b1;
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANE_W = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              word_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              unaligned_o
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] ea;

  assign ea          = base_i + {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
  assign lane_o      = ea[LANE_W-1:0];
  assign word_addr_o = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign unaligned_o = word_i & (|ea[LANE_W-1:0]);
endmodule

// File: rtl/lsu_store_fmt.sv
module lsu_store_fmt #(
  parameter int DATA_W    = 32,
  parameter int NUM_LANES = DATA_W / 8,
  parameter int LANE_W    = $clog2(NUM_LANES)
) (
  input  logic [LANE_W-1:0]    lane_i,
  input  logic                 word_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic [NUM_LANES-1:0] be_o,
  output logic [DATA_W-1:0]    wdata_o
);
  logic [NUM_LANES-1:0][7:0] src_lanes;
  logic [NUM_LANES-1:0][7:0] out_lanes;

  assign src_lanes = data_i;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign be_o[g]      = word_i | (lane_i == LANE_W'(g));
    assign out_lanes[g] = word_i ? src_lanes[g] : src_lanes[0];
  end

  assign wdata_o = out_lanes;
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt #(
  parameter int DATA_W    = 32,
  parameter int NUM_LANES = DATA_W / 8,
  parameter int LANE_W    = $clog2(NUM_LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              word_i,
  input  logic              sext_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic              pend_q, word_q, sext_q;
  logic [LANE_W-1:0] lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      word_q <= 1'b0;
      sext_q <= 1'b0;
      lane_q <= '0;
    end else begin
      pend_q <= issue_i;
      if (issue_i) begin
        word_q <= word_i;
        sext_q <= sext_i;
        lane_q <= lane_i;
      end
    end
  end

  logic [NUM_LANES-1:0][7:0] rd_lanes;
  logic [7:0]                pick;

  assign rd_lanes = rdata_i;
  assign pick     = rd_lanes[lane_q];

  always_comb begin
    if (word_q) data_o = rdata_i;
    else        data_o = {{(DATA_W-8){sext_q & pick[7]}}, pick};
  end

  assign valid_o = pend_q;
endmodule

// File: rtl/lsu_top.sv
module lsu_top
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] store_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              misalign_o,
  output logic              wb_valid_o,
  output logic [DATA_W-1:0] wb_data_o
);
  localparam int NUM_LANES = DATA_W / 8;
  localparam int LANE_W    = $clog2(NUM_LANES);

  lsu_dec_t          dec;
  logic              active, unaligned;
  logic [LANE_W-1:0] lane;

  assign dec    = lsu_decode(op_i);
  assign active = req_valid_i & (dec.load | dec.store);

  lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_addr (
    .base_i      (base_i),
    .offset_i    (offset_i),
    .word_i      (dec.word),
    .word_addr_o (mem_addr_o),
    .lane_o      (lane),
    .unaligned_o (unaligned)
  );

  assign misalign_o = active & unaligned;
  assign mem_req_o  = active & ~unaligned;
  assign mem_we_o   = mem_req_o & dec.store;

  lsu_store_fmt #(.DATA_W(DATA_W), .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_st (
    .lane_i  (lane),
    .word_i  (dec.word),
    .data_i  (store_data_i),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o)
  );

  lsu_load_fmt #(.DATA_W(DATA_W), .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_ld (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (mem_req_o & dec.load),
    .word_i  (dec.word),
    .sext_i  (dec.sext),
    .lane_i  (lane),
    .rdata_i (mem_rdata_i),
    .valid_o (wb_valid_o),
    .data_o  (wb_data_o)
  );

  AST_FAULT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (!mem_req_o && !mem_we_o)); // R2
  AST_FAULT_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> !wb_valid_o); // R2
  AST_WB_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> wb_valid_o); // R3
  AST_WB_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(mem_req_o && !mem_we_o)); // R9
  AST_WORD_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && dec.word) |-> (mem_be_o == '1)); // R4
  AST_BYTE_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !dec.word) |-> ($countones(mem_be_o) == 1)); // R7
  AST_BYTE_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !dec.word) |-> !misalign_o); // R8
endmodule

// File: tb/lsu_top_tb_top.sv
module lsu_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [31:0] base_i = '0;
  logic [15:0] offset_i = '0;
  logic [31:0] store_data_i = '0;
  logic        mem_req_o, mem_we_o, misalign_o, wb_valid_o;
  logic [31:0] mem_addr_o, mem_wdata_o, wb_data_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_rdata_i;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  lsu_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .op_i(op_i),
    .base_i(base_i), .offset_i(offset_i), .store_data_i(store_data_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .misalign_o(misalign_o), .wb_valid_o(wb_valid_o), .wb_data_o(wb_data_o)
  );

  // Synchronous word memory, 16 words
  logic [31:0] mem [16];
  always_ff @(posedge clk_i) begin
    if (mem_req_o && mem_we_o) begin
      for (int b = 0; b < 4; b++)
        if (mem_be_o[b]) mem[mem_addr_o[5:2]][b*8 +: 8] <= mem_wdata_o[b*8 +: 8];
    end else if (mem_req_o) begin
      mem_rdata_i <= mem[mem_addr_o[5:2]];
    end
  end

  // Captured results of the last request
  logic        s_req, s_we, s_mis, s_wbv;
  logic [31:0] s_addr, s_wdata, s_wbd;
  logic [3:0]  s_be;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [2:0] op, input logic [31:0] base,
                       input logic [15:0] off, input logic [31:0] sd);
    @(negedge clk_i);
    req_valid_i = v; op_i = op; base_i = base; offset_i = off; store_data_i = sd;
    #1;
    s_req = mem_req_o; s_we = mem_we_o; s_mis = misalign_o;
    s_addr = mem_addr_o; s_be = mem_be_o; s_wdata = mem_wdata_o;
    @(negedge clk_i);
    s_wbv = wb_valid_o; s_wbd = wb_data_o;
    req_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(wb_valid_o == 1'b0, "R9 reset wb_valid", {31'b0, wb_valid_o}, 32'h0);
    chk(mem_req_o == 1'b0, "R9 reset mem_req", {31'b0, mem_req_o}, 32'h0);
  endtask

  task automatic t_word;
    issue(1, 3'd1, 32'h20, 16'hFFFC, 32'hDEADBEEF);
    chk(s_addr == 32'h1C, "R1 word store addr", s_addr, 32'h1C);
    chk(s_req && s_we, "R4 word store strobes", {30'b0, s_req, s_we}, 32'h3);
    chk(s_be == 4'hF, "R4 word store be", {28'b0, s_be}, 32'hF);
    chk(s_wdata == 32'hDEADBEEF, "R4 word store data", s_wdata, 32'hDEADBEEF);
    issue(1, 3'd0, 32'h1C, 16'h0, 32'h0);
    chk(s_req && !s_we, "R3 word load strobes", {30'b0, s_req, s_we}, 32'h2);
    chk(s_wbv && s_wbd == 32'hDEADBEEF, "R3 word load data", s_wbd, 32'hDEADBEEF);
    issue(1, 3'd1, 32'h30, 16'hFFF8, 32'h01234567);
    chk(s_addr == 32'h28, "R1 negative offset addr", s_addr, 32'h28);
  endtask

  task automatic t_misalign;
    for (int k = 1; k < 4; k++) begin
      issue(1, 3'd1, 32'h1C + k, 16'h0, 32'h11111111);
      chk(s_mis && !s_req && !s_we, "R2 misaligned store", {29'b0, s_mis, s_req, s_we}, 32'h4);
      issue(1, 3'd0, 32'h1C, 16'(k), 32'h0);
      chk(s_mis && !s_req, "R2 misaligned load flag", {30'b0, s_mis, s_req}, 32'h2);
      chk(!s_wbv, "R2 misaligned load no wb", {31'b0, s_wbv}, 32'h0);
    end
    issue(1, 3'd0, 32'h1C, 16'h0, 32'h0);
    chk(s_wbd == 32'hDEADBEEF, "R2 memory untouched", s_wbd, 32'hDEADBEEF);
  endtask

  task automatic t_byte_loads;
    logic [31:0] sx [4];
    logic [31:0] zx [4];
    sx[0] = 32'h15; sx[1] = 32'hFFFFFFC3; sx[2] = 32'h7F; sx[3] = 32'hFFFFFF80;
    zx[0] = 32'h15; zx[1] = 32'hC3;       zx[2] = 32'h7F; zx[3] = 32'h80;
    issue(1, 3'd1, 32'h10, 16'h0, 32'h807FC315);
    for (int n = 0; n < 4; n++) begin
      issue(1, 3'd2, 32'h10 + n, 16'h0, 32'h0);
      chk(!s_mis, "R8 byte load no fault", {31'b0, s_mis}, 32'h0);
      chk(s_wbv && s_wbd == sx[n], "R5 signed byte lane", s_wbd, sx[n]);
      issue(1, 3'd3, 32'h10, 16'(n), 32'h0);
      chk(s_wbv && s_wbd == zx[n], "R6 unsigned byte lane", s_wbd, zx[n]);
    end
  endtask

  task automatic t_byte_store;
    issue(1, 3'd4, 32'h11, 16'h1, 32'hAAAAAA5A);
    chk(!s_mis && s_req && s_we, "R8 byte store accepted", {29'b0, s_mis, s_req, s_we}, 32'h3);
    chk(s_be == 4'b0100, "R7 byte store be", {28'b0, s_be}, 32'h4);
    chk(s_wdata == 32'h5A5A5A5A, "R7 byte store data", s_wdata, 32'h5A5A5A5A);
    issue(1, 3'd0, 32'h10, 16'h0, 32'h0);
    chk(s_wbd == 32'h805AC315, "R7 neighbours kept", s_wbd, 32'h805AC315);
    issue(1, 3'd4, 32'h13, 16'h0, 32'h000000EE);
    chk(s_be == 4'b1000, "R7 byte store lane3 be", {28'b0, s_be}, 32'h8);
    issue(1, 3'd0, 32'h10, 16'h0, 32'h0);
    chk(s_wbd == 32'hEE5AC315, "R7 lane3 written", s_wbd, 32'hEE5AC315);
  endtask

  task automatic t_idle;
    issue(0, 3'd1, 32'h10, 16'h0, 32'h0);
    chk(!s_req && !s_we && !s_wbv, "R9 idle no access", {29'b0, s_req, s_we, s_wbv}, 32'h0);
    for (int o = 5; o < 8; o++) begin
      issue(1, 3'(o), 32'h10, 16'h0, 32'h0);
      chk(!s_req && !s_wbv && !s_mis, "R9 unused op", {29'b0, s_req, s_wbv, s_mis}, 32'h0);
    end
    issue(1, 3'd0, 32'h10, 16'h0, 32'h0);
    chk(s_wbd == 32'hEE5AC315, "R9 memory untouched", s_wbd, 32'hEE5AC315);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem_rdata_i = '0;
    #1;
    t_reset;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_word;
    t_misalign;
    t_byte_loads;
    t_byte_store;
    t_idle;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule